// File: doc/BRIEF.md
# Prioritized DMA Event Queue

This block sits between a set of DMA channels and a row of transfer controllers. Each channel raises a one-cycle event pulse when it wants service. The event is held as pending until the channel wins a per-cycle priority contest. The winning channel number is then appended to the tail of the FIFO queue named by that channel's queue-select input. Regular DMA channels take the low channel numbers. Quick channels follow them, so any regular channel outranks any quick channel.

There is one queue per transfer controller, and queue n feeds controller n only. Each cycle at most one queue hands its head entry to its controller. Only queues whose controller shows ready take part. Among those, the lowest-numbered queue is served. A second event on a channel that is still pending is not queued again; it sets a sticky missed-event flag for that channel, which software clears.

Top module: `dmaq_evt_queue`

## Requirements
- R1: After reset no channel is pending, every queue is empty, `tc_take` is all zero and `miss_flag` is all zero.
- R2: An event pulse on a channel that is not pending makes it pending at the next clock edge. A pending channel that wins is written into the queue given by its queue-select field at the following edge, and stops being pending there. The field is sampled at that edge. Channel c is a regular channel for c < N_DMA (field bits `dma_qsel[c*QW +: QW]`) and quick channel c-N_DMA otherwise (field bits `qdma_qsel`).
- R3: At most one channel is enqueued per cycle: the lowest-numbered eligible pending channel. Regular channels have numbers 0..N_DMA-1 and quick channels N_DMA..N_DMA+N_QDMA-1.
- R4: Each queue holds up to Q_DEPTH (16) entries and hands them out in arrival order.
- R5: A pending channel whose selected queue is full is not eligible and stays pending. Meanwhile the lowest pending channel whose queue has room wins. Fullness is judged before any dequeue in the same cycle.
- R6: An event on a channel that is already pending, including one in the cycle it wins, sets `miss_flag[c]` and adds no queue entry. `miss_clr[c]` clears the flag; a set in the same cycle takes precedence over the clear.
- R7: `tc_take[q]` is high in a cycle when queue q is non-empty, `tc_ready[q]` is high, and no lower-numbered queue is non-empty with its controller ready. In that cycle `tc_chan[q*CW +: CW]` shows the head channel number, and the entry is removed at the clock edge. At most one bit of `tc_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_evt | input | N_DMA | Event pulses of regular channels |
| qdma_evt | input | N_QDMA | Event pulses of quick channels |
| dma_qsel | input | N_DMA*QW | Queue-select field per regular channel |
| qdma_qsel | input | N_QDMA*QW | Queue-select field per quick channel |
| miss_clr | input | N_DMA+N_QDMA | Clears the missed-event flag per channel |
| tc_ready | input | N_Q | Controller q can accept an entry |
| tc_take | output | N_Q | Queue q hands its head to controller q this cycle |
| tc_chan | output | N_Q*CW | Head channel number of each queue |
| miss_flag | output | N_DMA+N_QDMA | Sticky missed-event flag per channel |

## Verification
The first test is a lone event on an idle system. It separates the event-to-pending-to-queue latency from any arbitration effect. Firing every channel in one cycle with the controllers stalled shows the enqueue order, regular before quick and lowest first, through the drain order of each queue. Repeated events on one channel against a stalled controller fill that queue, which shows the full-queue hold and that another channel bypasses it. Back-to-back pulses, and clear-versus-set collisions, exercise the missed-event flag. A final long stretch of random events, remapping and ready patterns is compared cycle by cycle against a behavioural model. It mixes dequeue priority with simultaneous enqueue and dequeue on the same queue.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    localparam int unsigned DMAQ_N_DMA   = 8;
    localparam int unsigned DMAQ_N_QDMA  = 4;
    localparam int unsigned DMAQ_N_Q     = 4;
    localparam int unsigned DMAQ_DEPTH   = 16;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dmaq_pick.sv
module dmaq_pick #(
    parameter int unsigned W = 8,
    localparam int unsigned IW = dmaq_pkg::idx_w(W)
) (
    input  logic [W-1:0]  req,
    output logic [W-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Lowest set bit wins: walk downward so the last hit is the lowest.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 4,
    localparam int unsigned PW   = dmaq_pkg::idx_w(DEPTH),
    localparam int unsigned NW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [NW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign full  = (st_q.cnt == NW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/dmaq_evt_queue.sv
module dmaq_evt_queue #(
    parameter int unsigned N_DMA   = dmaq_pkg::DMAQ_N_DMA,
    parameter int unsigned N_QDMA  = dmaq_pkg::DMAQ_N_QDMA,
    parameter int unsigned N_Q     = dmaq_pkg::DMAQ_N_Q,
    parameter int unsigned Q_DEPTH = dmaq_pkg::DMAQ_DEPTH,
    localparam int unsigned NCH    = N_DMA + N_QDMA,
    localparam int unsigned CW     = dmaq_pkg::idx_w(NCH),
    localparam int unsigned QW     = dmaq_pkg::idx_w(N_Q)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_DMA-1:0]     dma_evt,
    input  logic [N_QDMA-1:0]    qdma_evt,
    input  logic [N_DMA*QW-1:0]  dma_qsel,
    input  logic [N_QDMA*QW-1:0] qdma_qsel,
    input  logic [NCH-1:0]       miss_clr,
    input  logic [N_Q-1:0]       tc_ready,
    output logic [N_Q-1:0]       tc_take,
    output logic [N_Q*CW-1:0]    tc_chan,
    output logic [NCH-1:0]       miss_flag
);
    typedef struct packed {
        logic [NCH-1:0] pend;
        logic [NCH-1:0] miss;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NCH-1:0] evt;
    logic [QW-1:0]  ch_q [NCH];
    logic [N_Q-1:0] q_full, q_empty, q_push, deq_req;
    logic [CW-1:0]  q_head [N_Q];
    logic [NCH-1:0] elig, win_oh;
    logic [CW-1:0]  win_idx;
    logic           win_any;
    logic [QW-1:0]  deq_idx;
    logic           deq_any;

    assign evt = {qdma_evt, dma_evt};

    for (genvar c = 0; c < NCH; c++) begin : g_map
        if (c < N_DMA) begin : g_reg
            assign ch_q[c] = dma_qsel[c*QW +: QW];
        end else begin : g_quick
            assign ch_q[c] = qdma_qsel[(c-N_DMA)*QW +: QW];
        end
    end

    // A pending channel competes only while its queue has room.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            elig[c] = st_q.pend[c] && !q_full[ch_q[c]];
        end
    end

    dmaq_pick #(.W(NCH)) i_win_pick (
        .req (elig),
        .gnt (win_oh),
        .idx (win_idx),
        .any (win_any)
    );

    always_comb begin
        for (int q = 0; q < N_Q; q++) begin
            q_push[q]  = win_any && (ch_q[win_idx] == QW'(q));
            deq_req[q] = !q_empty[q] && tc_ready[q];
        end
    end

    dmaq_pick #(.W(N_Q)) i_deq_pick (
        .req (deq_req),
        .gnt (tc_take),
        .idx (deq_idx),
        .any (deq_any)
    );

    for (genvar q = 0; q < N_Q; q++) begin : g_queue
        dmaq_fifo #(.DEPTH(Q_DEPTH), .DW(CW)) i_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[q]),
            .push_data (win_idx),
            .pop       (tc_take[q]),
            .head      (q_head[q]),
            .full      (q_full[q]),
            .empty     (q_empty[q])
        );
        assign tc_chan[q*CW +: CW] = q_head[q];
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~win_oh) | (evt & ~st_q.pend);
        st_d.miss = (st_q.miss & ~miss_clr) | (evt & st_q.pend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss_flag = st_q.miss;

    // R7
    take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_take));
    // R3
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_push));
    // R7
    take_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_any |-> tc_ready[deq_idx]);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2
        win_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_oh[c] |=> !st_q.pend[c]);
        // R6
        miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.miss[c]) |-> $past(evt[c] && st_q.pend[c]));
        // R5
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[c] && q_full[ch_q[c]]) |=> st_q.pend[c]);
    end
endmodule

// File: tb/test_dmaq_evt_queue.sv
module test_dmaq_evt_queue;
    localparam int ND = 8, NQD = 4, NQ = 4, DEP = 16, NCH = 12, CW = 4, QW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ND-1:0]     dma_evt = '0;
    logic [NQD-1:0]    qdma_evt = '0;
    logic [ND*QW-1:0]  dma_qsel = '0;
    logic [NQD*QW-1:0] qdma_qsel = '0;
    logic [NCH-1:0]    miss_clr = '0;
    logic [NQ-1:0]     tc_ready = '0;
    logic [NQ-1:0]     tc_take;
    logic [NQ*CW-1:0]  tc_chan;
    logic [NCH-1:0]    miss_flag;

    dmaq_evt_queue i_dmaq_evt_queue (
        .clk(clk), .rst_n(rst_n), .dma_evt(dma_evt), .qdma_evt(qdma_evt),
        .dma_qsel(dma_qsel), .qdma_qsel(qdma_qsel), .miss_clr(miss_clr),
        .tc_ready(tc_ready), .tc_take(tc_take), .tc_chan(tc_chan),
        .miss_flag(miss_flag)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R1";

    bit m_pend [NCH];
    bit m_miss [NCH];
    int mq [NQ][$];

    task automatic chk(bit ok, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    function automatic int qof(int c);
        if (c < ND) return int'(dma_qsel[c*QW +: QW]);
        return int'(qdma_qsel[(c-ND)*QW +: QW]);
    endfunction

    function automatic int missv();
        int v = 0;
        for (int c = 0; c < NCH; c++) if (m_miss[c]) v |= (1 << c);
        return v;
    endfunction

    // One cycle: compare outputs with the model, advance the model, clock.
    task automatic step();
        int g = -1;
        int w = -1;
        bit [NCH-1:0] ev;
        #1;
        for (int q = 0; q < NQ; q++)
            if (g < 0 && mq[q].size() > 0 && tc_ready[q]) g = q;
        for (int q = 0; q < NQ; q++) begin
            chk(tc_take[q] == (q == g), $sformatf("tc_take[%0d]", q), int'(tc_take[q]), int'(q == g));
            if (q == g)
                chk(int'(tc_chan[q*CW +: CW]) == mq[q][0], $sformatf("tc_chan[%0d]", q),
                    int'(tc_chan[q*CW +: CW]), mq[q][0]);
        end
        chk(int'(miss_flag) == missv(), "miss_flag", int'(miss_flag), missv());
        for (int c = 0; c < NCH; c++)
            if (w < 0 && m_pend[c] && mq[qof(c)].size() < DEP) w = c;
        ev = {qdma_evt, dma_evt};
        if (g >= 0) void'(mq[g].pop_front());
        if (w >= 0) mq[qof(w)].push_back(w);
        for (int c = 0; c < NCH; c++) begin
            m_miss[c] = (m_miss[c] && !miss_clr[c]) || (ev[c] && m_pend[c]);
            m_pend[c] = (m_pend[c] && c != w) || (ev[c] && !m_pend[c]);
        end
        @(posedge clk);
        @(negedge clk);
        dma_evt = '0; qdma_evt = '0; miss_clr = '0;
    endtask

    task automatic pulse(int c);
        if (c < ND) dma_evt[c] = 1'b1;
        else        qdma_evt[c-ND] = 1'b1;
    endtask

    task automatic setq(int c, int q);
        if (c < ND) dma_qsel[c*QW +: QW] = QW'(q);
        else        qdma_qsel[(c-ND)*QW +: QW] = QW'(q);
    endtask

    task automatic drain();
        tc_ready = '1;
        for (int i = 0; i < 80; i++) step();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        tc_ready = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(tc_take == '0, "R1 tc_take after reset", int'(tc_take), 0);
        chk(miss_flag == '0, "R1 miss_flag after reset", int'(miss_flag), 0);
        for (int i = 0; i < 4; i++) step();

        // R2: lone event, channel 3 to queue 2, then quick channel 10 to queue 1
        tag = "R2";
        setq(3, 2); setq(10, 1);
        pulse(3);
        for (int i = 0; i < 4; i++) step();
        pulse(10);
        for (int i = 0; i < 4; i++) step();

        // R3: every channel at once with controllers stalled
        tag = "R3";
        tc_ready = '0;
        for (int c = 0; c < NCH; c++) begin setq(c, (c * 3) % NQ); pulse(c); end
        for (int i = 0; i < 14; i++) step();
        drain();

        // R5: queue 0 filled by channel 0 while channel 1 bypasses to queue 1
        tag = "R5";
        tc_ready = '0;
        setq(0, 0); setq(1, 1);
        for (int i = 0; i < 19; i++) begin pulse(0); step(); step(); end
        pulse(1);
        for (int i = 0; i < 4; i++) step();

        // R4: FIFO order out of a full queue, simultaneous push and pop
        tag = "R4";
        tc_ready = 4'b0001;
        for (int i = 0; i < 20; i++) step();
        drain();

        // R6: back-to-back pulses, clear, clear against set
        tag = "R6";
        tc_ready = '0;
        pulse(9); step();
        pulse(9); step();
        step();
        miss_clr[9] = 1'b1; step();
        pulse(9); step();
        pulse(9); miss_clr[9] = 1'b1; step();
        step();
        miss_clr = '1; step();
        drain();

        // R7: all queues loaded, varied ready patterns
        tag = "R7";
        tc_ready = '0;
        for (int c = 0; c < NCH; c++) begin setq(c, c % NQ); pulse(c); end
        for (int i = 0; i < 14; i++) step();
        tc_ready = 4'b1010; for (int i = 0; i < 3; i++) step();
        tc_ready = 4'b0100; for (int i = 0; i < 2; i++) step();
        tc_ready = 4'b1111; for (int i = 0; i < 6; i++) step();
        drain();

        // Mixed random traffic against the model
        tag = "R3/R7 random";
        for (int i = 0; i < 4000; i++) begin
            dma_evt  = ND'($urandom & $urandom);
            qdma_evt = NQD'($urandom & $urandom);
            tc_ready = NQ'($urandom);
            if (($urandom % 8) == 0) miss_clr = NCH'($urandom);
            if (($urandom % 64) == 0) begin
                dma_qsel = ND*QW'($urandom);
                qdma_qsel = NQD*QW'($urandom);
            end
            step();
        end
        drain();

        summary();
        $finish;
    end
endmodule